// File: doc/BRIEF.md
# Selectable Three-Waveform Sample Generator

This block produces a single unsigned 8-bit sample stream that carries a square, triangle or sine wave. A 2-bit select input chooses which wave is shown. From a fast system clock, a clock-enable divider produces a one-cycle step pulse. Each pulse moves a 4-bit phase index one place through a 16-entry table held for every waveform. All three tables are looked up in parallel, and the select input picks the one that is output.

With the default divide ratio of 5,000,000 and a 40 MHz clock, the phase advances at 8 Hz, so each 16-sample period lasts 2 seconds. Next to the binary sample, the block gives the same value as three BCD digits (hundreds, tens, ones) for a numeric display. The digits change on the same clock edge as the sample. The D/A converter and any segment encoding sit outside this block.

Top module: `wave_synth_top`

## Requirements
- R1: While `rst_n` is low, `sample_o` and all three digits read 0. Reset also clears the phase index and the divider, so the first phase step takes effect exactly `TICK_DIV` edges after reset is released.
- R2: The phase index advances by one every `TICK_DIV` clock cycles. The sample for phase p appears at edge p*`TICK_DIV`+1 after reset release and holds through edge (p+1)*`TICK_DIV`.
- R3: The phase index wraps from 15 to 0, so each period holds exactly 16 samples, and phase 16 repeats the sample of phase 0.
- R4: Select code 2'b00 (square) outputs 255 for phases 0–7 and 0 for phases 8–15.
- R5: Select code 2'b01 (triangle) outputs 32·k for phases k = 0..7, 255 at phase 8, and 32·(16−k) for phases 9–15.
- R6: Select code 2'b10 (sine) outputs, for phases 0..15: 128,176,218,245,255,245,218,176,128,79,37,10,0,10,37,79.
- R7: Select code 2'b11 outputs a constant 0.
- R8: A change of select shows at the output one edge later. It does not disturb the phase index.
- R9: `dig_hund`, `dig_tens` and `dig_ones` are the BCD digits of `sample_o` and update on the same edge. Each digit is 0–9, and the hundreds digit is never above 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wave_sel | input | 2 | Waveform choice: 00 square, 01 triangle, 10 sine, 11 zero |
| sample_o | output | 8 | Selected unsigned sample |
| dig_hund | output | 4 | Hundreds digit of the sample, BCD |
| dig_tens | output | 4 | Tens digit of the sample, BCD |
| dig_ones | output | 4 | Ones digit of the sample, BCD |

## Verification
The sample for phase p is due at edge p*`TICK_DIV`+1 after reset release: the divider flags the last count, the phase register steps on the following edge, and the output register takes the new table value one edge after that. A select change is due one edge after it is driven, and the digits are due on the same edge as the sample. The bench runs with a small divide ratio, counts edges from a reset released on a falling edge, and samples every result on a falling edge at exactly these counts. To pin the latency, it also checks the last edge before each step.

// File: rtl/wave_pkg.sv
package wave_pkg;

  localparam int SAMPLE_W   = 8;
  localparam int PHASE_W    = 4;
  localparam int NUM_PHASES = 1 << PHASE_W;
  localparam int NUM_WAVES  = 3;
  localparam int DIGITS     = 3;
  localparam int SAMPLE_MAX = (1 << SAMPLE_W) - 1;
  localparam int TRI_STEP   = (SAMPLE_MAX + 1) / (NUM_PHASES / 2);

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [PHASE_W-1:0]  phase_t;

  localparam logic [1:0] SEL_SQUARE = 2'b00;
  localparam logic [1:0] SEL_TRI    = 2'b01;
  localparam logic [1:0] SEL_SINE   = 2'b10;

  localparam int WAVE_SQUARE = 0;
  localparam int WAVE_TRI    = 1;
  localparam int WAVE_SINE   = 2;

  function automatic sample_t square_at(phase_t idx);
    return (int'(idx) < NUM_PHASES / 2) ? sample_t'(SAMPLE_MAX) : '0;
  endfunction

  function automatic sample_t tri_at(phase_t idx);
    int lvl;
    if (int'(idx) <= NUM_PHASES / 2) lvl = TRI_STEP * int'(idx);
    else                             lvl = TRI_STEP * (NUM_PHASES - int'(idx));
    if (lvl > SAMPLE_MAX) lvl = SAMPLE_MAX;
    return sample_t'(lvl);
  endfunction

  function automatic sample_t sine_at(phase_t idx);
    sample_t v;
    case (idx)
      4'd0:    v = 8'd128;
      4'd1:    v = 8'd176;
      4'd2:    v = 8'd218;
      4'd3:    v = 8'd245;
      4'd4:    v = 8'd255;
      4'd5:    v = 8'd245;
      4'd6:    v = 8'd218;
      4'd7:    v = 8'd176;
      4'd8:    v = 8'd128;
      4'd9:    v = 8'd79;
      4'd10:   v = 8'd37;
      4'd11:   v = 8'd10;
      4'd12:   v = 8'd0;
      4'd13:   v = 8'd10;
      4'd14:   v = 8'd37;
      default: v = 8'd79;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/wave_tick_div.sv
module wave_tick_div #(
  parameter int unsigned TICK_DIV = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = at_last;

  always_comb begin
    if (at_last) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wave_phase_ctr.sv
module wave_phase_ctr
  import wave_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_en,
  output phase_t phase_o
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (step_en) phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/wave_tables.sv
module wave_tables
  import wave_pkg::*;
(
  input  phase_t  phase_i,
  output sample_t wave_o [NUM_WAVES]
);
  for (genvar g = 0; g < NUM_WAVES; g++) begin : g_wave
    if (g == WAVE_SQUARE) begin : g_sq
      assign wave_o[g] = square_at(phase_i);
    end else if (g == WAVE_TRI) begin : g_tri
      assign wave_o[g] = tri_at(phase_i);
    end else begin : g_sin
      assign wave_o[g] = sine_at(phase_i);
    end
  end
endmodule

// File: rtl/wave_bcd.sv
module wave_bcd #(
  parameter int IN_W   = 8,
  parameter int DIGITS = 3
) (
  input  logic [IN_W-1:0]     bin_i,
  output logic [4*DIGITS-1:0] bcd_o
);
  localparam int BCD_W = 4 * DIGITS;

  logic [BCD_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[4*d +: 4] >= 4'd5) acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
      end
      acc = {acc[BCD_W-2:0], bin_i[i]};
    end
  end

  assign bcd_o = acc;
endmodule

// File: rtl/wave_synth_top.sv
module wave_synth_top
  import wave_pkg::*;
#(
  parameter int unsigned TICK_DIV = 5_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wave_sel,
  output logic [7:0] sample_o,
  output logic [3:0] dig_hund,
  output logic [3:0] dig_tens,
  output logic [3:0] dig_ones
);
  localparam int BCD_W = 4 * DIGITS;

  logic             tick;
  phase_t           phase;
  sample_t          waves [NUM_WAVES];
  sample_t          pick_d, sample_q;
  logic [BCD_W-1:0] bcd_d, bcd_q;

  wave_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(tick)
  );

  wave_phase_ctr u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(tick),
    .phase_o(phase)
  );

  wave_tables u_tables (
    .phase_i(phase),
    .wave_o (waves)
  );

  always_comb begin
    case (wave_sel)
      SEL_SQUARE: pick_d = waves[WAVE_SQUARE];
      SEL_TRI:    pick_d = waves[WAVE_TRI];
      SEL_SINE:   pick_d = waves[WAVE_SINE];
      default:    pick_d = '0;
    endcase
  end

  wave_bcd #(.IN_W(SAMPLE_W), .DIGITS(DIGITS)) u_bcd (
    .bin_i(pick_d),
    .bcd_o(bcd_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      bcd_q    <= '0;
    end else begin
      sample_q <= pick_d;
      bcd_q    <= bcd_d;
    end
  end

  assign sample_o = sample_q;
  assign dig_hund = bcd_q[11:8];
  assign dig_tens = bcd_q[7:4];
  assign dig_ones = bcd_q[3:0];
endmodule

// File: rtl/wave_synth_checker.sv
module wave_synth_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [3:0] phase,
  input logic [1:0] wave_sel,
  input logic [7:0] sample_o,
  input logic [3:0] dig_hund,
  input logic [3:0] dig_tens,
  input logic [3:0] dig_ones
);
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase == 4'($past(phase) + 4'd1));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wave_sel == 2'b11 |=> sample_o == 8'd0);

  a_r9_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    dig_hund <= 4'd2 && dig_tens <= 4'd9 && dig_ones <= 4'd9);

  a_r9_digit_value: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dig_hund) * 100 + int'(dig_tens) * 10 + int'(dig_ones) == int'(sample_o));
endmodule

bind wave_synth_top wave_synth_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .phase   (phase),
  .wave_sel(wave_sel),
  .sample_o(sample_o),
  .dig_hund(dig_hund),
  .dig_tens(dig_tens),
  .dig_ones(dig_ones)
);

// File: tb/wave_synth_top_test.sv
`timescale 1ns/1ps
module wave_synth_top_test;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] wave_sel;
  logic [7:0] sample_o;
  logic [3:0] dig_hund, dig_tens, dig_ones;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  wave_synth_top #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wave_sel(wave_sel),
    .sample_o(sample_o), .dig_hund(dig_hund),
    .dig_tens(dig_tens), .dig_ones(dig_ones)
  );

  function automatic int exp_wave(int sel, int k);
    int sine_tab [16] = '{128,176,218,245,255,245,218,176,128,79,37,10,0,10,37,79};
    case (sel)
      0: return (k < 8) ? 255 : 0;
      1: return (k < 8) ? 32 * k : (k == 8 ? 255 : 32 * (16 - k));
      2: return sine_tab[k];
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic check_sample(string req, int expected);
    check(req, int'(sample_o), expected);
    check("R9", int'(dig_hund), expected / 100);
    check("R9", int'(dig_tens), (expected / 10) % 10);
    check("R9", int'(dig_ones), expected % 10);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Apply reset with a select value; return just after edge 1 after release.
  task automatic restart(logic [1:0] sel);
    @(negedge clk);
    rst_n    = 1'b0;
    wave_sel = sel;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n    = 1'b0;
    wave_sel = 2'b10;
    step(3);
    check_sample("R1", 0);
    rst_n = 1'b1;
    step(1);
    check_sample("R6", 128);
  endtask

  task automatic t_timing;
    restart(2'b01);
    step(DIV - 1);
    check_sample("R2", 0);
    step(1);
    check_sample("R2", 32);
    step(DIV - 1);
    check_sample("R2", 32);
    step(1);
    check_sample("R2", 64);
  endtask

  task automatic t_wave(logic [1:0] sel, string req);
    restart(sel);
    for (int p = 0; p < 16; p++) begin
      check_sample(req, exp_wave(int'(sel), p));
      step(DIV);
    end
    check_sample("R3", exp_wave(int'(sel), 0));
    step(DIV);
    check_sample("R3", exp_wave(int'(sel), 1));
  endtask

  task automatic t_idle;
    restart(2'b11);
    for (int p = 0; p < 6; p++) begin
      check_sample("R7", 0);
      step(DIV);
    end
  endtask

  task automatic t_switch;
    restart(2'b00);
    step(3 * DIV);
    check_sample("R4", 255);
    wave_sel = 2'b10;
    step(1);
    check_sample("R8", 245);
    wave_sel = 2'b01;
    step(1);
    check_sample("R8", 96);
    step(DIV - 2);
    check_sample("R8", 128);
  endtask

  initial begin
    rst_n    = 1'b0;
    wave_sel = 2'b00;
    t_reset();
    t_timing();
    t_wave(2'b00, "R4");
    t_wave(2'b01, "R5");
    t_wave(2'b10, "R6");
    t_idle();
    t_switch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule